// File: doc/BRIEF.md
# Multi-mode accumulator instruction sequencer

This block is the control sequencer and datapath of a small 8-bit accumulator machine with a 16-bit address space. It fetches one-byte opcodes and their operand bytes from a byte-wide memory port. The memory returns read data in the same cycle as the address, and the block samples it at the next rising clock edge. Every clock cycle is one micro-operation. The block holds the program counter, accumulator A, index register X, a 16-bit temporary register and four condition flags.

Two instruction families are supported, add-to-A and load-A, each in four operand modes:
- immediate (data follows the opcode);
- page-zero direct (one address byte, upper byte forced to zero);
- extended (a full address, high byte first);
- indexed (X plus an unsigned offset byte).

There is also a one-byte clear-A instruction. Any other opcode is a one-byte, two-cycle no-operation. X is written only through a load port. The block pulses a done strobe in the last cycle of every instruction.

The control is a state machine with seven states:
- FETCH: reads the opcode at PC and advances PC.
- IMM: reads the data byte at PC, advances PC and executes.
- ADRH: reads the high address byte into the temporary register and advances PC.
- ADRL: reads the low address byte or the offset byte and advances PC. In the direct and indexed modes it clears the temporary register's high byte.
- EAX: adds X to the temporary register, discarding the carry out.
- EXEC: reads the operand at the temporary register's address and executes.
- INH: executes clear-A or the no-operation without a memory read.

The transitions are:
- FETCH goes to IMM for immediate opcodes, to ADRL for direct and indexed opcodes, to ADRH for extended opcodes, and to INH for all others.
- ADRH goes to ADRL.
- ADRL goes to EAX in the indexed mode and to EXEC otherwise.
- EAX goes to EXEC.
- IMM, EXEC and INH return to FETCH.

Top module: `acc_seq`

## Requirements
- R1: While reset is low, PC takes the value of `rst_addr`, and A, X and all flags are zero. `done` is low and `mem_addr` equals `rst_addr`. The first opcode fetch after reset is from `rst_addr`.
- R2: Opcode 0x8B (add immediate) is two bytes long and takes 2 cycles. In its second cycle it reads the data byte at PC and sets A to A plus that byte, modulo 256. For example, 0x12 plus 0x33 gives 0x45.
- R3: Opcode 0x9B (add direct) is two bytes long and takes 3 cycles. The operand is read in the final cycle from address {0x00, address byte}.
- R4: Opcode 0xBB (add extended) is three bytes long and takes 4 cycles. The first operand byte is the high address byte and the second is the low address byte. The operand is read from the full 16-bit address.
- R5: Opcode 0xAB (add indexed) is two bytes long and takes 4 cycles. The operand address is X plus the offset byte treated as unsigned, kept modulo 2^16. For example, X=0x0100 with offset 0x80 gives 0x0180, and X=0xFFF0 with offset 0x20 gives 0x0010.
- R6: After any add, `flags` = {N,Z,V,C} (bit 3 down to bit 0) is set as follows: N is result bit 7, and Z is set when the result is zero. V is set when both addends have the same sign and the result's sign differs. C is the carry out of bit 7.
- R7: The load opcodes 0x86, 0x96, 0xB6 and 0xA6 use the immediate, direct, extended and indexed sequences, lengths and cycle counts of R2 to R5. They write the operand into A, set N and Z from it, clear V and leave C unchanged.
- R8: Opcode 0x4F is one byte long and takes 2 cycles. It sets A to 0 and `flags` to 4'b0100.
- R9: Any opcode not listed in R2, R3, R4, R5, R7 or R8 is one byte long and takes 2 cycles, and leaves A and the flags unchanged.
- R10: PC advances by one for each opcode or operand byte read. The next opcode fetch is from the address just past the last byte of the current instruction.
- R11: When `x_load` is high at a rising edge, X takes `x_value`. Otherwise X keeps its value.
- R12: `done` is high only in the final cycle of each instruction. A and the flags change only at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_addr | input | 16 | Address of the first opcode after reset |
| mem_addr | output | 16 | Memory read address for the current cycle |
| mem_rdata | input | 8 | Byte read from `mem_addr`, valid in the same cycle |
| x_load | input | 1 | Load X from `x_value` at the next edge |
| x_value | input | 16 | New value for X |
| acc | output | 8 | Accumulator A |
| flags | output | 4 | {N,Z,V,C} condition flags |
| done | output | 1 | High in the final cycle of an instruction |

## Verification
Each run places a program in memory at the reset address. Operand data comes from an address-dependent function, so any wrong operand address appears as a wrong accumulator value. The operand-address check in the last cycle also tells apart the immediate, page-zero, extended and indexed address forms. A sweep cycles through every supported opcode, an unknown opcode and clear-A, with operand bytes stepped arithmetically. The sweep is repeated with three X values, one of which makes the indexed address wrap past 0xFFFF. Fixed pairs of a load followed by an add produce signed overflow, carry with a zero result, and both together, which separates V from C. Counting cycles between done strobes, and checking each next fetch address, exposes any wrong sequence length or PC step.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OPW = 8;

    localparam logic [OPW-1:0] OP_ADD_IMM = 8'h8B;
    localparam logic [OPW-1:0] OP_ADD_DIR = 8'h9B;
    localparam logic [OPW-1:0] OP_ADD_EXT = 8'hBB;
    localparam logic [OPW-1:0] OP_ADD_IDX = 8'hAB;
    localparam logic [OPW-1:0] OP_LD_IMM  = 8'h86;
    localparam logic [OPW-1:0] OP_LD_DIR  = 8'h96;
    localparam logic [OPW-1:0] OP_LD_EXT  = 8'hB6;
    localparam logic [OPW-1:0] OP_LD_IDX  = 8'hA6;
    localparam logic [OPW-1:0] OP_CLR     = 8'h4F;

    typedef enum logic [2:0] {
        ST_FETCH, ST_IMM, ST_ADRH, ST_ADRL, ST_EAX, ST_EXEC, ST_INH
    } st_t;

    typedef enum logic [1:0] {OPK_NOP, OPK_ADD, OPK_LOAD, OPK_CLR} opk_t;

    typedef enum logic [2:0] {AM_INH, AM_IMM, AM_DIR, AM_EXT, AM_IDX} am_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/acc_seq_dec.sv
module acc_seq_dec
    import acc_seq_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output opk_t           kind,
    output am_t            mode
);
    always_comb begin
        kind = OPK_NOP;
        mode = AM_INH;
        case (opcode)
            OP_ADD_IMM: begin kind = OPK_ADD;  mode = AM_IMM; end
            OP_ADD_DIR: begin kind = OPK_ADD;  mode = AM_DIR; end
            OP_ADD_EXT: begin kind = OPK_ADD;  mode = AM_EXT; end
            OP_ADD_IDX: begin kind = OPK_ADD;  mode = AM_IDX; end
            OP_LD_IMM:  begin kind = OPK_LOAD; mode = AM_IMM; end
            OP_LD_DIR:  begin kind = OPK_LOAD; mode = AM_DIR; end
            OP_LD_EXT:  begin kind = OPK_LOAD; mode = AM_EXT; end
            OP_LD_IDX:  begin kind = OPK_LOAD; mode = AM_IDX; end
            OP_CLR:     begin kind = OPK_CLR;  mode = AM_INH; end
            default:    begin kind = OPK_NOP;  mode = AM_INH; end
        endcase
    end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  opk_t          kind,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  ccr_t          f_in,
    output logic [DW-1:0] res,
    output ccr_t          f_out
);
    logic [DW:0] sum;

    assign sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        res   = a;
        f_out = f_in;
        unique case (kind)
            OPK_ADD: begin
                res     = sum[DW-1:0];
                f_out.n = sum[DW-1];
                f_out.z = (sum[DW-1:0] == '0);
                f_out.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
                f_out.c = sum[DW];
            end
            OPK_LOAD: begin
                res     = b;
                f_out.n = b[DW-1];
                f_out.z = (b == '0);
                f_out.v = 1'b0;
            end
            OPK_CLR: begin
                res   = '0;
                f_out = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            end
            OPK_NOP: begin
                res   = a;
                f_out = f_in;
            end
        endcase
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rst_addr,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          x_load,
    input  logic [AW-1:0] x_value,
    output logic [DW-1:0] acc,
    output logic [3:0]    flags,
    output logic          done
);
    localparam int HI = AW - DW;

    st_t           st_q, st_d;
    opk_t          kind_q, dec_kind;
    am_t           mode_q, dec_mode;
    logic [AW-1:0] pc_q, x_q, thr_q;
    logic [DW-1:0] acc_q, alu_res;
    ccr_t          ccr_q, alu_f;
    logic          pc_inc, exec;

    acc_seq_dec u_dec (
        .opcode (mem_rdata[OPW-1:0]),
        .kind   (dec_kind),
        .mode   (dec_mode)
    );

    acc_seq_alu #(.DW(DW)) u_alu (
        .kind  (kind_q),
        .a     (acc_q),
        .b     (mem_rdata),
        .f_in  (ccr_q),
        .res   (alu_res),
        .f_out (alu_f)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FETCH;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d     = st_q;
        mem_addr = pc_q;
        pc_inc   = 1'b0;
        exec     = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_FETCH: begin
                pc_inc = 1'b1;
                unique case (dec_mode)
                    AM_IMM:         st_d = ST_IMM;
                    AM_DIR, AM_IDX: st_d = ST_ADRL;
                    AM_EXT:         st_d = ST_ADRH;
                    AM_INH:         st_d = ST_INH;
                    default:        st_d = ST_INH;
                endcase
            end
            ST_IMM: begin
                pc_inc = 1'b1;
                exec   = 1'b1;
                done   = 1'b1;
                st_d   = ST_FETCH;
            end
            ST_ADRH: begin
                pc_inc = 1'b1;
                st_d   = ST_ADRL;
            end
            ST_ADRL: begin
                pc_inc = 1'b1;
                st_d   = (mode_q == AM_IDX) ? ST_EAX : ST_EXEC;
            end
            ST_EAX: begin
                mem_addr = thr_q;
                st_d     = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = thr_q;
                exec     = 1'b1;
                done     = 1'b1;
                st_d     = ST_FETCH;
            end
            ST_INH: begin
                exec = 1'b1;
                done = 1'b1;
                st_d = ST_FETCH;
            end
            default: st_d = ST_FETCH;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= rst_addr;
            x_q    <= '0;
            thr_q  <= '0;
            acc_q  <= '0;
            ccr_q  <= '0;
            kind_q <= OPK_NOP;
            mode_q <= AM_INH;
        end else begin
            if (x_load) x_q <= x_value;
            if (pc_inc) pc_q <= pc_q + 1'b1;
            if (st_q == ST_FETCH) begin
                kind_q <= dec_kind;
                mode_q <= dec_mode;
            end
            case (st_q)
                ST_ADRH: thr_q[AW-1 -: DW] <= mem_rdata;
                ST_ADRL: begin
                    if (mode_q == AM_EXT) thr_q[DW-1:0] <= mem_rdata;
                    else                  thr_q <= {{HI{1'b0}}, mem_rdata};
                end
                ST_EAX:  thr_q <= thr_q + x_q;
                default: ;
            endcase
            if (exec) begin
                acc_q <= alu_res;
                ccr_q <= alu_f;
            end
        end
    end

    assign acc   = acc_q;
    assign flags = ccr_q;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input st_t           st_q,
    input opk_t          kind_q,
    input am_t           mode_q,
    input logic [AW-1:0] pc_q,
    input logic [AW-1:0] x_q,
    input logic [AW-1:0] mem_addr,
    input logic          x_load,
    input logic [AW-1:0] x_value,
    input logic [DW-1:0] acc,
    input logic [3:0]    flags,
    input logic          done
);
    // R10: an opcode fetch always steps PC by one
    p_fetch_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && st_q == ST_FETCH |=> pc_q == $past(pc_q) + 1'b1);

    // R3: direct operand read stays in page zero
    p_dir_page0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EXEC && mode_q == AM_DIR |-> mem_addr[AW-1:DW] == '0);

    // R8: clear leaves A zero and flags 0100
    p_clr_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && done && kind_q == OPK_CLR |=> acc == '0 && flags == 4'b0100);

    // R9: unknown opcodes change nothing
    p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && done && kind_q == OPK_NOP |=> $stable(acc) && $stable(flags));

    // R7: load clears V and keeps C
    p_load_vc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && done && kind_q == OPK_LOAD |=> !flags[1] && flags[0] == $past(flags[0]));

    // R11: X written only by the load port
    p_x_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !x_load |=> $stable(x_q));

    p_x_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && x_load |=> x_q == $past(x_value));

    // R12: A and flags change only at the end of an instruction
    p_quiet_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !done |=> $stable(acc) && $stable(flags));

endmodule

bind acc_seq acc_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_q     (st_q),
    .kind_q   (kind_q),
    .mode_q   (mode_q),
    .pc_q     (pc_q),
    .x_q      (x_q),
    .mem_addr (mem_addr),
    .x_load   (x_load),
    .x_value  (x_value),
    .acc      (acc),
    .flags    (flags),
    .done     (done)
);

// File: tb/tb_acc_seq.sv
module tb_acc_seq;

    localparam logic [15:0] BASE = 16'h4000;
    localparam int MAXI = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_load = 1'b0;
    logic [15:0] x_value = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  acc;
    logic [3:0]  flags;
    logic        done;

    always #10 clk = ~clk;

    logic [7:0] prog [0:255];

    function automatic logic [7:0] data_fn(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata = (mem_addr[15:8] == BASE[15:8]) ? prog[mem_addr[7:0]] : data_fn(mem_addr);

    acc_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_addr  (BASE),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .x_load    (x_load),
        .x_value   (x_value),
        .acc       (acc),
        .flags     (flags),
        .done      (done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected instruction list
    logic [7:0]  exp_acc  [MAXI];
    logic [3:0]  exp_flg  [MAXI];
    int          exp_cyc  [MAXI];
    logic [15:0] exp_ea   [MAXI];
    bit          exp_chk  [MAXI];
    logic [15:0] exp_next [MAXI];
    string       exp_req  [MAXI];

    logic [7:0]  m_a;
    logic [3:0]  m_f;
    logic [15:0] m_x;
    int          ppos, nins;

    task automatic start_phase(input logic [15:0] xv);
        for (int i = 0; i < 256; i++) prog[i] = 8'h01;
        ppos = 0; nins = 0; m_a = '0; m_f = '0; m_x = xv;
    endtask

    task automatic emit(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
        logic [15:0] pc0, ea;
        logic [7:0]  v, r;
        logic [8:0]  s;
        int          len, cyc;
        bit          chk;
        string       req;
        pc0 = BASE + 16'(ppos);
        ea = '0; chk = 1'b1; len = 2; cyc = 2; req = "R9";
        case (op)
            8'h8B, 8'h86: begin ea = pc0 + 16'd1; v = b1; req = (op == 8'h8B) ? "R2 R6" : "R7"; end
            8'h9B, 8'h96: begin cyc = 3; ea = {8'h00, b1}; v = data_fn(ea); req = (op == 8'h9B) ? "R3 R6" : "R7"; end
            8'hBB, 8'hB6: begin len = 3; cyc = 4; ea = {b1, b2}; v = data_fn(ea); req = (op == 8'hBB) ? "R4 R6" : "R7"; end
            8'hAB, 8'hA6: begin cyc = 4; ea = m_x + {8'h00, b1}; v = data_fn(ea); req = (op == 8'hAB) ? "R5 R6" : "R7"; end
            default:      begin len = 1; chk = 1'b0; v = '0; req = (op == 8'h4F) ? "R8" : "R9"; end
        endcase
        prog[ppos[7:0]] = op;
        if (len > 1) prog[8'(ppos + 1)] = b1;
        if (len > 2) prog[8'(ppos + 2)] = b2;
        case (op)
            8'h8B, 8'h9B, 8'hBB, 8'hAB: begin
                s = {1'b0, m_a} + {1'b0, v};
                r = s[7:0];
                m_f = {r[7], r == 8'h00, (m_a[7] == v[7]) && (r[7] != m_a[7]), s[8]};
                m_a = r;
            end
            8'h86, 8'h96, 8'hB6, 8'hA6: begin
                m_a = v;
                m_f = {v[7], v == 8'h00, 1'b0, m_f[0]};
            end
            8'h4F: begin m_a = '0; m_f = 4'b0100; end
            default: ;
        endcase
        exp_acc[nins] = m_a; exp_flg[nins] = m_f; exp_cyc[nins] = cyc;
        exp_ea[nins] = ea; exp_chk[nins] = chk; exp_next[nins] = pc0 + 16'(len);
        exp_req[nins] = req;
        ppos += len; nins++;
    endtask

    task automatic sweep(input int count, input int seed);
        logic [7:0] ops [11];
        logic [7:0] b1, b2;
        ops = '{8'h8B, 8'h9B, 8'hBB, 8'hAB, 8'h86, 8'h96, 8'hB6, 8'hA6, 8'h4F, 8'h01, 8'h1B};
        for (int k = 0; k < count; k++) begin
            b1 = 8'(k * 29 + 7 + seed);
            b2 = 8'(k * 53 + 1 + seed);
            if ((ops[k % 11] == 8'hBB || ops[k % 11] == 8'hB6) && b1 == BASE[15:8]) b1 = b1 + 8'd1;
            emit(ops[k % 11], b1, b2);
        end
    endtask

    // monitor
    bit running = 1'b0;
    bit pending = 1'b0;
    int mon_idx = 0, pi = 0, cnt = 0;

    always @(negedge clk) begin
        #8;
        if (running) begin
            if (pending) begin
                check(acc == exp_acc[pi], exp_req[pi], "acc", int'(acc), int'(exp_acc[pi]));
                check(flags == exp_flg[pi], exp_req[pi], "flags", int'(flags), int'(exp_flg[pi]));
                check(mem_addr == exp_next[pi], "R10", "next fetch addr", int'(mem_addr), int'(exp_next[pi]));
                pending = 1'b0;
            end
            cnt++;
            if (done && mon_idx < nins) begin
                check(cnt == exp_cyc[mon_idx], {exp_req[mon_idx], " R12"}, "cycles", cnt, exp_cyc[mon_idx]);
                if (exp_chk[mon_idx])
                    check(mem_addr == exp_ea[mon_idx], exp_req[mon_idx], "operand addr",
                          int'(mem_addr), int'(exp_ea[mon_idx]));
                pi = mon_idx;
                pending = 1'b1;
                mon_idx++;
            end
            if (done) cnt = 0;
        end
    end

    task automatic run_phase(input logic [15:0] xv);
        int guard;
        @(negedge clk);
        rst_n = 1'b0; x_load = 1'b0;
        repeat (3) @(negedge clk);
        #8;
        check(acc == 8'h00, "R1", "reset acc", int'(acc), 0);
        check(flags == 4'h0, "R1", "reset flags", int'(flags), 0);
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
        check(mem_addr == BASE, "R1", "reset fetch addr", int'(mem_addr), int'(BASE));
        @(negedge clk);
        rst_n = 1'b1; x_load = 1'b1; x_value = xv;   // R11: X loaded via port
        mon_idx = 0; pending = 1'b0; cnt = 0; running = 1'b1;
        @(negedge clk);
        x_load = 1'b0;
        guard = 0;
        while ((mon_idx < nins || pending) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        running = 1'b0;
        if (guard >= 4000) begin
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog: actual %0d expected %0d done strobes", mon_idx, nins);
        end
    endtask

    initial begin
        // phase A: X = 0x0100, fixed flag cases then sweep
        start_phase(16'h0100);
        emit(8'h86, 8'h12, 8'h00); emit(8'h8B, 8'h33, 8'h00);   // 0x45
        emit(8'h86, 8'h7F, 8'h00); emit(8'h8B, 8'h01, 8'h00);   // V, N
        emit(8'h86, 8'hFF, 8'h00); emit(8'h8B, 8'h01, 8'h00);   // Z, C
        emit(8'h86, 8'h80, 8'h00); emit(8'h8B, 8'h80, 8'h00);   // Z, V, C
        emit(8'h86, 8'h00, 8'h00);                               // C kept
        emit(8'h4F, 8'h00, 8'h00);
        emit(8'hAB, 8'h80, 8'h00);                               // EA 0x0180
        emit(8'h9B, 8'h33, 8'h00);
        emit(8'hBB, 8'h01, 8'h33);
        emit(8'h01, 8'h00, 8'h00);
        sweep(80, 0);
        run_phase(16'h0100);

        // phase B: X near top, indexed wrap
        start_phase(16'hFFF0);
        emit(8'hAB, 8'h20, 8'h00);                               // EA 0x0010
        emit(8'hA6, 8'hFF, 8'h00);
        sweep(88, 3);
        run_phase(16'hFFF0);

        // phase C: another X
        start_phase(16'h1234);
        emit(8'h96, 8'hFF, 8'h00);
        sweep(88, 11);
        run_phase(16'h1234);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule